// File: doc/BRIEF.md
# Sideband Reply Reassembler and Checker

This block collects the reply to a sideband request. The reply arrives as one or more chunks, and each chunk sits in a polled reply window. For every chunk, the block polls a service vector byte until the reply-ready bit is set. It then reads the whole window one byte at a time. While it reads, it parses the chunk header, checks the header CRC and the body CRC, and appends the body data bytes to an internal reply buffer. It then writes the vector byte to acknowledge the chunk.

The block stops reading chunks when one of them carries the end-of-transaction flag. It then reports one of these outcomes: success, NACK (with a reason code), CRC error, buffer overflow, or timeout while waiting for a chunk.

The transport is not part of this block. It serves all byte reads and writes through a simple request/acknowledge port. Software or a later block reads the reassembled reply through a read port on the buffer.

Top module: `sbr_reply_assembler`

## Requirements
- R1: Before reading each chunk, the block issues vector polls (`xfer_op`=0). It reads no window byte until a poll returns a byte with bit 4 set. The other bits of the returned byte are ignored.
- R2: Each accepted chunk is read with window reads (`xfer_op`=1). The reads cover offsets 0 up to 79, exactly once each, in ascending order.
- R3: After a chunk passes both CRC checks, the block performs exactly one vector write (`xfer_op`=2) with data 0x10.
- R4: Header layout:
  - Byte 0 holds the link count in bits 7:4.
  - Then come floor(link count / 2) packed address bytes.
  - Then comes a byte whose bits 5:0 give the body length, which includes the CRC byte.
  - Then comes a byte with end-of-transaction in bit 6 and the header CRC in bits 3:0.
  - The body follows directly after the header.
- R5: The header CRC uses polynomial x^4+x+1, starts at 0, and is computed MSB first over all header bits except the CRC nibble. A mismatch ends the reply with status 3 and no vector write for that chunk.
- R6: The body CRC uses polynomial x^8+x^7+x^6+x^4+x^2+1, starts at 0, and is computed MSB first over the body data bytes. The last body byte carries the expected value. A mismatch ends the reply with status 3.
- R7: Only body data bytes (body length minus one per chunk) go into the buffer. `reply_len` counts them. Buffer entry i is read combinationally at `buf_raddr`=i.
- R8: Chunks keep arriving until one has end-of-transaction set. Their data is concatenated in arrival order.
- R9: If bit 7 of reassembled byte 0 is set, the status is 2 (NACK) and `nack_reason` holds reassembled byte 17. Otherwise the status is 1 (OK) and `nack_reason` is 0.
- R10: If a data byte arrives while the buffer already holds `BUF_DEPTH` bytes, the reply ends with status 4. Filling the buffer exactly is not an error.
- R11: If `POLL_LIMIT` consecutive polls return not-ready, the reply ends with status 5. One fewer such poll does not end it.
- R12:
  - After reset, `done`, `status` and `reply_len` are 0.
  - A `start` pulse clears `done` one cycle later.
  - A `start` pulse during a reply is ignored.
  - Once `done` is set, it stays set with `status`, `reply_len` and `nack_reason` stable, and no transfer is requested, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin receiving a reply |
| xfer_req | output | 1 | Transfer request, held until acknowledged |
| xfer_op | output | 2 | 0 poll vector byte, 1 read window byte, 2 write vector byte |
| xfer_addr | output | clog2(WIN_BYTES) | Window byte offset for reads |
| xfer_wdata | output | 8 | Data for the vector write |
| xfer_ack | input | 1 | Transfer completes in the cycle it is high with `xfer_req` |
| xfer_rdata | input | 8 | Read data, valid with `xfer_ack` |
| done | output | 1 | Reply finished, held until next start |
| status | output | 3 | 0 none, 1 OK, 2 NACK, 3 CRC error, 4 overflow, 5 timeout |
| reply_len | output | clog2(BUF_DEPTH)+1 | Number of data bytes in the buffer |
| nack_reason | output | 8 | Reason byte of a NACK reply |
| buf_raddr | input | clog2(BUF_DEPTH) | Buffer read address |
| buf_rdata | output | 8 | Buffer byte at `buf_raddr` |

## Verification
Two situations are hard to reach from the ports:
- Filling the buffer to exactly its capacity, versus overflowing it by one chunk.
- A CRC failure in a later chunk after earlier chunks were accepted and acknowledged.

The bench uses a reduced 32-byte buffer and a short poll limit. A transport model serves scripted windows. The bench computes each window's CRCs by augmented polynomial division, and can corrupt one chosen CRC field in one chosen chunk. A sweep over every link count from 1 to 15 moves the body start across all header lengths.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int SB_WIN_BYTES  = 80;
    localparam int SB_READY_BIT  = 4;
    localparam int SB_NACK_BYTE  = 17;
    localparam logic [7:0] SB_CLEAR_BYTE = 8'h10;
    localparam logic [7:0] CRC4_POLY = 8'h03;
    localparam logic [7:0] CRC8_POLY = 8'hD5;

    typedef enum logic [1:0] {
        OP_POLL  = 2'd0,
        OP_WIN   = 2'd1,
        OP_CLEAR = 2'd2
    } sb_op_e;

    typedef enum logic [2:0] {
        ST_NONE    = 3'd0,
        ST_OK      = 3'd1,
        ST_NACK    = 3'd2,
        ST_CRC     = 3'd3,
        ST_OVF     = 3'd4,
        ST_TIMEOUT = 3'd5
    } sb_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POLL,
        S_WIN,
        S_CHECK,
        S_CLEAR
    } sb_state_e;

    typedef struct packed {
        logic [3:0] lct;
        logic [5:0] len;
        logic       eomt;
        logic [3:0] hcrc;
        logic [7:0] bcrc;
    } sb_hdr_t;

    // Direct-form CRC over the top nbits of data, MSB first, in the low
    // width bits of crc_in.
    function automatic logic [7:0] crc_bits(input logic [7:0] crc_in,
                                            input logic [7:0] poly,
                                            input int width,
                                            input logic [7:0] data,
                                            input int nbits);
        logic [7:0] c;
        logic [7:0] mask;
        logic fb;
        c    = crc_in;
        mask = 8'((16'd1 << width) - 16'd1);
        for (int i = 0; i < 8; i++) begin
            if (i < nbits) begin
                fb = c[width-1] ^ data[7-i];
                c  = ((c << 1) & mask) ^ (fb ? poly : 8'h00);
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/sbr_crc_acc.sv
module sbr_crc_acc
    import sbr_pkg::*;
#(
    parameter int         W    = 4,
    parameter logic [7:0] POLY = CRC4_POLY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         half,
    input  logic [7:0]   data,
    output logic [W-1:0] crc
);

    logic [W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= W'(crc_bits(8'(acc_q), POLY, W, data, half ? 4 : 8));
        end
    end

    assign crc = acc_q;

endmodule

// File: rtl/sbr_reply_buf.sv
module sbr_reply_buf #(
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [7:0]                 wr_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [7:0]                 rd_data
);

    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] cnt_q;

    assign full = (cnt_q == LW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (wr_en && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            mem[cnt_q[AW-1:0]] <= wr_data;
        end
    end

    assign count   = cnt_q;
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sbr_reply_assembler.sv
module sbr_reply_assembler
    import sbr_pkg::*;
#(
    parameter int BUF_DEPTH  = 256,
    parameter int POLL_LIMIT = 1024,
    parameter int WIN_BYTES  = SB_WIN_BYTES,
    parameter int NACK_BYTE  = SB_NACK_BYTE
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    output logic                           xfer_req,
    output logic [1:0]                     xfer_op,
    output logic [$clog2(WIN_BYTES)-1:0]   xfer_addr,
    output logic [7:0]                     xfer_wdata,
    input  logic                           xfer_ack,
    input  logic [7:0]                     xfer_rdata,
    output logic                           done,
    output logic [2:0]                     status,
    output logic [$clog2(BUF_DEPTH):0]     reply_len,
    output logic [7:0]                     nack_reason,
    input  logic [$clog2(BUF_DEPTH)-1:0]   buf_raddr,
    output logic [7:0]                     buf_rdata
);

    localparam int PW = $clog2(WIN_BYTES);
    localparam int AW = $clog2(BUF_DEPTH);
    localparam int LW = AW + 1;
    localparam int CW = $clog2(POLL_LIMIT + 1);
    localparam logic [PW-1:0] LAST_POS = PW'(WIN_BYTES - 1);

    sb_state_e      state_q;
    sb_op_e         op_q;
    sb_status_e     status_q;
    sb_hdr_t        hdr_q;
    logic           req_q;
    logic           done_q;
    logic [PW-1:0]  pos_q;
    logic [CW-1:0]  polls_q;
    logic           nack_flag_q;
    logic [7:0]     reason_cap_q;
    logic [7:0]     reason_q;

    logic [LW-1:0]  buf_count;
    logic           buf_full;
    logic [3:0]     hcrc_calc;
    logic [7:0]     bcrc_calc;

    // Byte classification for the window byte being accepted
    logic           fire, win_fire;
    logic [7:0]     pos8, hdr_len, body_lim;
    logic           hdr_full, hdr_last, len_byte, data_byte, bcrc_byte;
    logic           app_en, overflow;
    logic           begin_reply, next_chunk, crc_clr;

    always_comb begin
        fire      = req_q && xfer_ack;
        win_fire  = fire && (state_q == S_WIN);
        pos8      = 8'(pos_q);
        hdr_len   = 8'd3 + 8'(hdr_q.lct >> 1);
        body_lim  = hdr_len + 8'(hdr_q.len);
        hdr_full  = win_fire && ((pos_q == '0) || (pos8 + 8'd1 < hdr_len));
        hdr_last  = win_fire && (pos_q != '0) && (pos8 + 8'd1 == hdr_len);
        len_byte  = win_fire && (pos_q != '0) && (pos8 + 8'd2 == hdr_len);
        data_byte = win_fire && (pos8 >= hdr_len) && (pos8 + 8'd1 < body_lim);
        bcrc_byte = win_fire && (hdr_q.len != '0) && (pos8 + 8'd1 == body_lim);
        app_en    = data_byte && !buf_full;
        overflow  = data_byte && buf_full;
        begin_reply = (state_q == S_IDLE) && start;
        next_chunk  = (state_q == S_CLEAR) && fire && !hdr_q.eomt;
        crc_clr     = begin_reply || next_chunk;
    end

    sbr_crc_acc #(.W(4), .POLY(CRC4_POLY)) u_hcrc (
        .clk  (clk),
        .rst  (rst),
        .clr  (crc_clr),
        .en   (hdr_full || hdr_last),
        .half (hdr_last),
        .data (xfer_rdata),
        .crc  (hcrc_calc)
    );

    sbr_crc_acc #(.W(8), .POLY(CRC8_POLY)) u_bcrc (
        .clk  (clk),
        .rst  (rst),
        .clr  (crc_clr),
        .en   (data_byte),
        .half (1'b0),
        .data (xfer_rdata),
        .crc  (bcrc_calc)
    );

    sbr_reply_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .clr     (begin_reply),
        .wr_en   (app_en),
        .wr_data (xfer_rdata),
        .count   (buf_count),
        .full    (buf_full),
        .rd_addr (buf_raddr),
        .rd_data (buf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            op_q         <= OP_POLL;
            status_q     <= ST_NONE;
            hdr_q        <= '0;
            req_q        <= 1'b0;
            done_q       <= 1'b0;
            pos_q        <= '0;
            polls_q      <= '0;
            nack_flag_q  <= 1'b0;
            reason_cap_q <= '0;
            reason_q     <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        done_q       <= 1'b0;
                        status_q     <= ST_NONE;
                        reason_q     <= '0;
                        reason_cap_q <= '0;
                        nack_flag_q  <= 1'b0;
                        pos_q        <= '0;
                        polls_q      <= '0;
                        state_q      <= S_POLL;
                    end
                end
                S_POLL: begin
                    if (!req_q) begin
                        req_q <= 1'b1;
                        op_q  <= OP_POLL;
                    end else if (xfer_ack) begin
                        req_q <= 1'b0;
                        if (xfer_rdata[SB_READY_BIT]) begin
                            pos_q   <= '0;
                            state_q <= S_WIN;
                        end else if (polls_q == CW'(POLL_LIMIT - 1)) begin
                            status_q <= ST_TIMEOUT;
                            done_q   <= 1'b1;
                            state_q  <= S_IDLE;
                        end else begin
                            polls_q <= polls_q + 1'b1;
                        end
                    end
                end
                S_WIN: begin
                    if (!req_q) begin
                        req_q <= 1'b1;
                        op_q  <= OP_WIN;
                    end else if (xfer_ack) begin
                        req_q <= 1'b0;
                        if (pos_q == '0) hdr_q.lct <= xfer_rdata[7:4];
                        if (len_byte)    hdr_q.len <= xfer_rdata[5:0];
                        if (hdr_last) begin
                            hdr_q.eomt <= xfer_rdata[6];
                            hdr_q.hcrc <= xfer_rdata[3:0];
                        end
                        if (bcrc_byte) hdr_q.bcrc <= xfer_rdata;
                        if (app_en && buf_count == '0) nack_flag_q <= xfer_rdata[7];
                        if (app_en && buf_count == LW'(NACK_BYTE)) reason_cap_q <= xfer_rdata;
                        if (overflow) begin
                            status_q <= ST_OVF;
                            done_q   <= 1'b1;
                            state_q  <= S_IDLE;
                        end else if (pos_q == LAST_POS) begin
                            state_q <= S_CHECK;
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                end
                S_CHECK: begin
                    if ((hcrc_calc != hdr_q.hcrc) ||
                        ((hdr_q.len != '0) && (bcrc_calc != hdr_q.bcrc))) begin
                        status_q <= ST_CRC;
                        done_q   <= 1'b1;
                        state_q  <= S_IDLE;
                    end else begin
                        state_q <= S_CLEAR;
                    end
                end
                S_CLEAR: begin
                    if (!req_q) begin
                        req_q <= 1'b1;
                        op_q  <= OP_CLEAR;
                    end else if (xfer_ack) begin
                        req_q <= 1'b0;
                        if (hdr_q.eomt) begin
                            status_q <= nack_flag_q ? ST_NACK : ST_OK;
                            reason_q <= nack_flag_q ? reason_cap_q : 8'h00;
                            done_q   <= 1'b1;
                            state_q  <= S_IDLE;
                        end else begin
                            polls_q <= '0;
                            pos_q   <= '0;
                            state_q <= S_POLL;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign xfer_req    = req_q;
    assign xfer_op     = op_q;
    assign xfer_addr   = pos_q;
    assign xfer_wdata  = (op_q == OP_CLEAR) ? SB_CLEAR_BYTE : 8'h00;
    assign done        = done_q;
    assign status      = status_q;
    assign reply_len   = buf_count;
    assign nack_reason = reason_q;

endmodule

// File: rtl/sbr_reply_assembler_chk.sv
module sbr_reply_assembler_chk #(
    parameter int BUF_DEPTH = 256,
    parameter int WIN_BYTES = 80
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           start,
    input logic                           xfer_req,
    input logic [1:0]                     xfer_op,
    input logic [$clog2(WIN_BYTES)-1:0]   xfer_addr,
    input logic                           xfer_ack,
    input logic                           done,
    input logic [2:0]                     status,
    input logic [$clog2(BUF_DEPTH):0]     reply_len,
    input logic [7:0]                     nack_reason
);

    localparam int PW = $clog2(WIN_BYTES);
    localparam int LW = $clog2(BUF_DEPTH) + 1;

    // R12: a pending request keeps its op and address until acknowledged
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_op) && $stable(xfer_addr)));

    // R2: window offsets stay inside the window
    a_r2_addr_range: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && xfer_op == 2'd1) |-> (xfer_addr < PW'(WIN_BYTES)));

    // R2: consecutive window reads step by one
    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && xfer_ack && xfer_op == 2'd1 && xfer_addr != PW'(WIN_BYTES - 1)
         && reply_len < LW'(BUF_DEPTH))
        |-> ##2 (xfer_req && xfer_op == 2'd1 && xfer_addr == PW'($past(xfer_addr, 2) + 1'b1)));

    // R12: result held while done and no start
    a_r12_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(status) && $stable(reply_len) && $stable(nack_reason)));

    // R12: no transfers once finished
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !xfer_req);

    // R12: start clears done
    a_r12_start_clears: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done);

    // R10: length never exceeds capacity
    a_r10_len_bound: assert property (@(posedge clk) disable iff (rst)
        reply_len <= LW'(BUF_DEPTH));

    // R9: a positive reply carries no reason code
    a_r9_ok_reason_zero: assert property (@(posedge clk) disable iff (rst)
        (done && status == 3'd1) |-> (nack_reason == 8'h00));

endmodule

bind sbr_reply_assembler sbr_reply_assembler_chk #(
    .BUF_DEPTH (BUF_DEPTH),
    .WIN_BYTES (WIN_BYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .xfer_req    (xfer_req),
    .xfer_op     (xfer_op),
    .xfer_addr   (xfer_addr),
    .xfer_ack    (xfer_ack),
    .done        (done),
    .status      (status),
    .reply_len   (reply_len),
    .nack_reason (nack_reason)
);

// File: tb/sbr_reply_assembler_tb.sv
`timescale 1ns/100ps
module sbr_reply_assembler_tb;

    localparam int DEPTH = 32;
    localparam int PLIM  = 8;
    localparam int WIN   = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       xfer_req;
    logic [1:0] xfer_op;
    logic [6:0] xfer_addr;
    logic [7:0] xfer_wdata;
    logic       xfer_ack = 1'b0;
    logic [7:0] xfer_rdata = 8'h00;
    logic       done;
    logic [2:0] status;
    logic [5:0] reply_len;
    logic [7:0] nack_reason;
    logic [4:0] buf_raddr = '0;
    logic [7:0] buf_rdata;

    always #2.5 clk = ~clk;

    sbr_reply_assembler #(.BUF_DEPTH(DEPTH), .POLL_LIMIT(PLIM)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .xfer_req(xfer_req), .xfer_op(xfer_op), .xfer_addr(xfer_addr),
        .xfer_wdata(xfer_wdata), .xfer_ack(xfer_ack), .xfer_rdata(xfer_rdata),
        .done(done), .status(status), .reply_len(reply_len),
        .nack_reason(nack_reason), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] win [0:7][0:WIN-1];
    int  notready [0:7];
    int  nchunks, cur, pollc, exp_addr, clears, polls_total;
    bit  seen_ready, st;
    logic [7:0] payload [0:255];
    bit  bitbuf [0:1023];
    int  nb;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Transport model, driven away from the active edge
    always @(negedge clk) begin
        xfer_ack = 1'b0;
        if (xfer_req && st) begin
            xfer_ack = 1'b1;
            case (xfer_op)
                2'd0: begin
                    polls_total++;
                    if (cur < nchunks && pollc >= notready[cur]) begin
                        xfer_rdata = 8'h13;
                        seen_ready = 1'b1;
                    end else begin
                        xfer_rdata = 8'hEF;
                        pollc++;
                    end
                end
                2'd1: begin
                    if (!seen_ready) chk(0, "R1", "window read before ready", 0, 1);
                    if (int'(xfer_addr) != exp_addr)
                        chk(0, "R2", "window offset", int'(xfer_addr), exp_addr);
                    exp_addr++;
                    xfer_rdata = win[cur][xfer_addr];
                end
                default: begin
                    if (xfer_wdata != 8'h10) chk(0, "R3", "clear data", int'(xfer_wdata), 16);
                    if (exp_addr != WIN) chk(0, "R2", "bytes read per chunk", exp_addr, WIN);
                    clears++;
                    cur++;
                    pollc = 0;
                    exp_addr = 0;
                    seen_ready = 1'b0;
                end
            endcase
        end
        st = ~st;
    end

    function automatic int div_crc(input int nbits, input int width, input int poly);
        int rem = 0;
        for (int k = 0; k < nbits; k++) begin
            rem = (rem << 1) | int'(bitbuf[k]);
            if (((rem >> width) & 1) == 1) rem = rem ^ poly;
        end
        for (int k = 0; k < width; k++) begin
            rem = rem << 1;
            if (((rem >> width) & 1) == 1) rem = rem ^ poly;
        end
        return rem & ((1 << width) - 1);
    endfunction

    task automatic push(input logic [7:0] b, input int n);
        for (int k = 0; k < n; k++) begin
            bitbuf[nb] = b[7-k];
            nb++;
        end
    endtask

    task automatic put_chunk(input int ci, input int lct, input int ndata, input int pstart,
                             input bit eomt, input bit bad_h, input bit bad_b);
        int p;
        logic [7:0] flags;
        int c4, c8;
        for (int i = 0; i < WIN; i++) win[ci][i] = 8'hA5 ^ 8'(i);
        win[ci][0] = {4'(lct), 4'(lct - 1)};
        p = 1;
        for (int r = 0; r < lct / 2; r++) begin
            win[ci][p] = 8'h5A ^ 8'(r * 17 + ci);
            p++;
        end
        win[ci][p] = {2'b00, 6'(ndata + 1)};
        p++;
        flags = {(ci == 0) ? 1'b1 : 1'b0, eomt, 1'b0, 1'(ci), 4'h0};
        nb = 0;
        for (int i = 0; i < p; i++) push(win[ci][i], 8);
        push(flags, 4);
        c4 = div_crc(nb, 4, 'h13);
        win[ci][p] = {flags[7:4], 4'(c4) ^ (bad_h ? 4'h1 : 4'h0)};
        p++;
        nb = 0;
        for (int d = 0; d < ndata; d++) begin
            win[ci][p + d] = payload[pstart + d];
            push(payload[pstart + d], 8);
        end
        c8 = div_crc(nb, 8, 'h1D5);
        win[ci][p + ndata] = 8'(c8) ^ (bad_b ? 8'h40 : 8'h00);
    endtask

    task automatic run_reply(input int n);
        nchunks = n;
        cur = 0; pollc = 0; exp_addr = 0; clears = 0; polls_total = 0;
        seen_ready = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b0, "R12", "done cleared after start", int'(done), 0);
        while (!done) @(negedge clk);
    endtask

    task automatic chk_content(input int len, input string req);
        int bad = 0;
        for (int i = 0; i < len; i++) begin
            buf_raddr = 5'(i);
            #0.2;
            if (buf_rdata != payload[i]) bad++;
        end
        chk(bad == 0, req, "buffer bytes mismatched", bad, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        st = 1'b0;
        for (int k = 0; k < 256; k++) payload[k] = 8'((k * 29 + 7) ^ (k >> 3));
        payload[0] = 8'h21;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(done == 1'b0, "R12", "reset done", int'(done), 0);
        chk(status == 3'd0, "R12", "reset status", int'(status), 0);
        chk(reply_len == 6'd0, "R12", "reset length", int'(reply_len), 0);
        chk(xfer_req == 1'b0, "R12", "reset request", int'(xfer_req), 0);

        // R1 R11: single chunk ready after PLIM-1 not-ready polls
        put_chunk(0, 1, 10, 0, 1'b1, 1'b0, 1'b0);
        notready[0] = PLIM - 1;
        run_reply(1);
        chk(status == 3'd1, "R11", "status after near-limit wait", int'(status), 1);
        chk(reply_len == 6'd10, "R7", "single chunk length", int'(reply_len), 10);
        chk(polls_total == PLIM, "R1", "polls issued", polls_total, PLIM);
        chk(clears == 1, "R3", "clear writes", clears, 1);
        chk(nack_reason == 8'h00, "R9", "reason on OK", int'(nack_reason), 0);
        chk_content(10, "R7");

        // R12 result held while idle
        repeat (30) @(negedge clk);
        chk(done && status == 3'd1 && reply_len == 6'd10, "R12", "held result",
            int'(status), 1);

        // R8: three chunks, start pulse mid-reply ignored
        put_chunk(0, 3, 12, 0,  1'b0, 1'b0, 1'b0);
        put_chunk(1, 3, 9,  12, 1'b0, 1'b0, 1'b0);
        put_chunk(2, 3, 5,  21, 1'b1, 1'b0, 1'b0);
        notready[0] = 2; notready[1] = 0; notready[2] = 3;
        fork
            run_reply(3);
            begin
                repeat (200) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        chk(status == 3'd1, "R8", "multi-chunk status", int'(status), 1);
        chk(reply_len == 6'd26, "R8", "multi-chunk length", int'(reply_len), 26);
        chk(clears == 3, "R8", "chunks acknowledged", clears, 3);
        chk(polls_total == 8, "R1", "polls over three chunks", polls_total, 8);
        chk_content(26, "R8");

        // R9: NACK reply, reason at reassembled byte 17
        payload[0] = 8'hA3;
        put_chunk(0, 2, 10, 0,  1'b0, 1'b0, 1'b0);
        put_chunk(1, 2, 14, 10, 1'b1, 1'b0, 1'b0);
        notready[0] = 0; notready[1] = 1;
        run_reply(2);
        chk(status == 3'd2, "R9", "NACK status", int'(status), 2);
        chk(nack_reason == payload[17], "R9", "NACK reason", int'(nack_reason), int'(payload[17]));
        chk(reply_len == 6'd24, "R9", "NACK length", int'(reply_len), 24);
        payload[0] = 8'h21;

        // R5: header CRC error in second chunk
        put_chunk(0, 1, 8, 0, 1'b0, 1'b0, 1'b0);
        put_chunk(1, 1, 8, 8, 1'b1, 1'b1, 1'b0);
        notready[0] = 0; notready[1] = 0;
        run_reply(2);
        chk(status == 3'd3, "R5", "header CRC status", int'(status), 3);
        chk(clears == 1, "R5", "clears before bad header", clears, 1);

        // R6: body CRC error, four-link header
        put_chunk(0, 4, 7, 0, 1'b1, 1'b0, 1'b1);
        notready[0] = 1;
        run_reply(1);
        chk(status == 3'd3, "R6", "body CRC status", int'(status), 3);
        chk(clears == 0, "R6", "no clear on bad body", clears, 0);

        // R10: overflow
        put_chunk(0, 1, 20, 0,  1'b0, 1'b0, 1'b0);
        put_chunk(1, 1, 20, 20, 1'b1, 1'b0, 1'b0);
        notready[0] = 0; notready[1] = 0;
        run_reply(2);
        chk(status == 3'd4, "R10", "overflow status", int'(status), 4);
        chk(reply_len == 6'd32, "R10", "length at overflow", int'(reply_len), 32);

        // R10: exact fill is accepted
        put_chunk(0, 1, 20, 0,  1'b0, 1'b0, 1'b0);
        put_chunk(1, 1, 12, 20, 1'b1, 1'b0, 1'b0);
        run_reply(2);
        chk(status == 3'd1, "R10", "exact fill status", int'(status), 1);
        chk(reply_len == 6'd32, "R10", "exact fill length", int'(reply_len), 32);
        chk_content(32, "R10");

        // R11: timeout at the limit
        put_chunk(0, 1, 4, 0, 1'b1, 1'b0, 1'b0);
        notready[0] = PLIM;
        run_reply(1);
        chk(status == 3'd5, "R11", "timeout status", int'(status), 5);
        chk(clears == 0, "R11", "no clear on timeout", clears, 0);
        chk(polls_total == PLIM, "R11", "polls before timeout", polls_total, PLIM);

        // R4: sweep every link count
        for (int lct = 1; lct <= 15; lct++) begin
            int nd;
            nd = 1 + (lct * 5) % 30;
            put_chunk(0, lct, nd, 0, 1'b1, 1'b0, 1'b0);
            notready[0] = lct % 3;
            run_reply(1);
            chk(status == 3'd1, "R4", $sformatf("status lct=%0d", lct), int'(status), 1);
            chk(int'(reply_len) == nd, "R4", $sformatf("length lct=%0d", lct),
                int'(reply_len), nd);
            chk_content(nd, "R4");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule